// File: doc/BRIEF.md
# Activate Admission Gate with Exact Four-Activate Window

This block decides, cycle by cycle, whether a DRAM row ACTIVATE may be sent on a channel whose banks are split into eight bank groups. It combines three limits. Two ACTIVATEs to one group need a short minimum gap. Two ACTIVATEs to different groups need a longer one. No more than four ACTIVATEs may fall inside any rolling window of `WINDOW` cycles, which guards the supply against bursts of row-opening current.

The window is tracked exactly. Each accepted ACTIVATE pushes its issue time into a four-slot queue, and each entry is retired on the very cycle its age reaches `WINDOW`. A single reloading timer would hold back legal commands; this queue does not. A command scheduler presents a target group and reads the `allow_o` flag in the same cycle. It ANDs that flag with its own per-bank readiness and then pulses `act_i`. A pulse made while the flag is low is dropped.

Top module: `act_window_gate`

## Requirements
- R1: `allow_o` is a combinational function of registered state and the present `grp_i`. Changing `grp_i` within a cycle changes the flag for that cycle. `grp_i` is a 3-bit binary group number, 0 to 7.
- R2: An accepted ACTIVATE issued at clock edge T stops counting against the window at edge T+`WINDOW`. It still counts at edge T+`WINDOW`-1.
- R3: Across any `WINDOW` consecutive clock edges, at most four ACTIVATEs are accepted.
- R4: After an ACTIVATE to group g is accepted at edge T, the flag for group g stays low until edge T+`SAME_GAP`.
- R5: After an ACTIVATE to group g is accepted at edge T, the flag for every other group stays low until edge T+`CROSS_GAP`.
- R6: The flag is high whenever the same-group gap, the cross-group gap and the window limit are all met. No legal ACTIVATE is held back.
- R7: An `act_i` pulse sampled while `allow_o` is low is ignored. It takes no window slot and restarts no gap.
- R8: When four ACTIVATEs are in the window and the oldest one expires on the same edge as a new request, the new ACTIVATE is accepted.
- R9: A synchronous active-low reset empties the window and clears all gaps. `allow_o` is high for every group in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| act_i | input | 1 | ACTIVATE request pulse for the group on `grp_i` |
| grp_i | input | GRP_W (3) | Target bank group number |
| allow_o | output | 1 | ACTIVATE to `grp_i` is permitted in this cycle |

## Verification
Every pair of source and target groups is tried with a request on every cycle after a first ACTIVATE. This shows the gap applied to the same group apart from the gap applied to other groups, and pins each edge to the exact cycle. A rotating stream of requests fills the window. It then shows whether the oldest entry is retired exactly `WINDOW` cycles later, in the same cycle a fifth request arrives. Random streams at light, medium and heavy request density, including many requests made while blocked, are checked every cycle against a model that keeps the accepted history. These streams separate a dropped pulse from one that wrongly took a slot or restarted a gap. A reset made while the window is full shows whether all state clears.

// File: rtl/act_gate_pkg.sv
// Package: act_gate_pkg
// Shared helper functions for the activate admission gate.
// Assumes all arguments are small positive integers.
package act_gate_pkg;

    // Larger of two integer values, used to size saturating counters.
    function automatic int larger_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold values 0..v inclusive, never less than 1.
    function automatic int bits_for(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/act_spacing_track.sv
// Module: act_spacing_track
// Keeps, for each bank group, the number of cycles since that group was
// last activated. The count saturates once no gap can still apply. It
// reports per group whether the same-group gap is met for that group and
// the cross-group gap is met against every other group.
// Assumes: SAME_GAP >= 1, CROSS_GAP >= 1, hit_i only when the ACTIVATE was
// admitted.
module act_spacing_track
    import act_gate_pkg::*;
#(
    parameter int GRP_W     = 3,
    parameter int SAME_GAP  = 4,
    parameter int CROSS_GAP = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hit_i,
    input  logic [GRP_W-1:0]         grp_i,
    output logic [(1<<GRP_W)-1:0]    ok_o
);
    localparam int NUM_GROUPS = 1 << GRP_W;
    localparam int SAT        = larger_of(SAME_GAP, CROSS_GAP);
    localparam int CW         = bits_for(SAT);
    localparam logic [CW-1:0] SAT_C   = CW'(SAT);
    localparam logic [CW-1:0] SAME_C  = CW'(SAME_GAP);
    localparam logic [CW-1:0] CROSS_C = CW'(CROSS_GAP);

    logic [CW-1:0]          since_q [NUM_GROUPS];
    logic [NUM_GROUPS-1:0]  same_ok;
    logic [NUM_GROUPS-1:0]  cross_ok;

    // Age every group counter; restart the one that was just activated.
    always_ff @(posedge clk) begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (!rst_n) begin
                since_q[g] <= SAT_C;
            end else if (hit_i && (grp_i == GRP_W'(g))) begin
                since_q[g] <= CW'(1);
            end else if (since_q[g] < SAT_C) begin
                since_q[g] <= since_q[g] + CW'(1);
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            // Per-group gap status derived from its counter.
            assign same_ok[g]  = (since_q[g] >= SAME_C);
            assign cross_ok[g] = (since_q[g] >= CROSS_C);
            // Group g passes if its own gap is met and all others are far enough back.
            assign ok_o[g] = same_ok[g] &
                             (&(cross_ok | (NUM_GROUPS'(1) << g)));

            if (SAME_GAP > 1) begin : g_same_chk
                // R4: the group just activated must be blocked on the next cycle.
                a_r4_same_gap_blocks: assert property (
                    @(posedge clk) disable iff (!rst_n)
                    (hit_i && (grp_i == GRP_W'(g))) |=> !ok_o[g]);
            end
        end
    endgenerate

endmodule

// File: rtl/act_stamp_queue.sv
// Module: act_stamp_queue
// Holds the issue times of admitted ACTIVATEs in a small circular queue.
// The oldest entry is retired on the cycle its age reaches WINDOW. Ages
// use modular subtraction against a free-running stamp, so this is exact
// while WINDOW < 2**TW.
// Assumes: push_i only when room_o is high.
module act_stamp_queue
    import act_gate_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int WINDOW = 32,
    parameter int TW     = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [TW-1:0]              now_i,
    output logic                       room_o,
    output logic                       pop_o,
    output logic [bits_for(DEPTH)-1:0] fill_o
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = bits_for(DEPTH);
    localparam logic [CNTW-1:0] FULL_C = CNTW'(DEPTH);
    localparam logic [TW-1:0]   WIN_C  = TW'(WINDOW);
    localparam logic [PW-1:0]   LAST_C = PW'(DEPTH - 1);

    logic [TW-1:0]   slot_q [DEPTH];
    logic [PW-1:0]   rd_q;
    logic [PW-1:0]   wr_q;
    logic [CNTW-1:0] fill_q;
    logic [TW-1:0]   head_age;

    // Age of the oldest entry, wraparound-safe.
    assign head_age = now_i - slot_q[rd_q];
    // Retire the oldest entry once it has spent a full window inside.
    assign pop_o    = (fill_q != '0) && (head_age >= WIN_C);
    // A slot is free now if the queue is not full or the oldest leaves this cycle.
    assign room_o   = (fill_q != FULL_C) || pop_o;
    assign fill_o   = fill_q;

    // Write stamps, advance pointers and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            wr_q   <= '0;
            fill_q <= '0;
            for (int s = 0; s < DEPTH; s++) slot_q[s] <= '0;
        end else begin
            if (push_i) begin
                slot_q[wr_q] <= now_i;
                wr_q         <= (wr_q == LAST_C) ? '0 : wr_q + PW'(1);
            end
            if (pop_o) begin
                rd_q <= (rd_q == LAST_C) ? '0 : rd_q + PW'(1);
            end
            case ({push_i, pop_o})
                2'b10:   fill_q <= fill_q + CNTW'(1);
                2'b01:   fill_q <= fill_q - CNTW'(1);
                default: fill_q <= fill_q;
            endcase
        end
    end

    // R3: the queue never holds more entries than its depth.
    a_r3_fill_bound: assert property (
        @(posedge clk) disable iff (!rst_n) fill_q <= FULL_C);

    // R3: nothing is pushed into a full queue that is not draining.
    a_r3_no_push_when_full: assert property (
        @(posedge clk) disable iff (!rst_n) push_i |-> room_o);

    // R2: an entry never outstays the window, so retirement is on time.
    a_r2_age_bound: assert property (
        @(posedge clk) disable iff (!rst_n) (fill_q != '0) |-> (head_age <= WIN_C));

endmodule

// File: rtl/act_window_gate.sv
// Module: act_window_gate (top)
// Admission gate for DRAM row ACTIVATEs. The flag is high when the
// same-group gap, the cross-group gap and the rolling four-activate window
// all permit an ACTIVATE to the group on grp_i. A request on act_i is
// admitted only while the flag is high; otherwise it leaves no trace.
// Assumes: the scheduler samples allow_o in the same cycle as it drives act_i.
module act_window_gate
    import act_gate_pkg::*;
#(
    parameter int GRP_W     = 3,
    parameter int SAME_GAP  = 4,
    parameter int CROSS_GAP = 8,
    parameter int WINDOW    = 32,
    parameter int WIN_ACTS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [GRP_W-1:0] grp_i,
    output logic             allow_o
);
    localparam int NUM_GROUPS = 1 << GRP_W;
    localparam int TW         = bits_for(WINDOW);
    localparam int CNTW       = bits_for(WIN_ACTS);

    logic [TW-1:0]         stamp_q;
    logic [NUM_GROUPS-1:0] gap_ok;
    logic                  room;
    logic                  pop;
    logic [CNTW-1:0]       fill;
    logic                  admit;

    // Free-running cycle stamp used to date each admitted ACTIVATE.
    always_ff @(posedge clk) begin
        if (!rst_n) stamp_q <= '0;
        else        stamp_q <= stamp_q + TW'(1);
    end

    act_spacing_track #(
        .GRP_W     (GRP_W),
        .SAME_GAP  (SAME_GAP),
        .CROSS_GAP (CROSS_GAP)
    ) u_spacing (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (admit),
        .grp_i (grp_i),
        .ok_o  (gap_ok)
    );

    act_stamp_queue #(
        .DEPTH  (WIN_ACTS),
        .WINDOW (WINDOW),
        .TW     (TW)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (admit),
        .now_i  (stamp_q),
        .room_o (room),
        .pop_o  (pop),
        .fill_o (fill)
    );

    // Flag for the selected group: gaps met and a window slot available.
    assign allow_o = gap_ok[grp_i] & room;
    // A request counts only when the flag grants it.
    assign admit   = act_i & allow_o;

    // R7: a refused request leaves the window occupancy to drain only.
    a_r7_refused_leaves_no_trace: assert property (
        @(posedge clk) disable iff (!rst_n)
        (act_i && !allow_o) |=> (fill == CNTW'($past(fill) - CNTW'($past(pop)))));

    // R6: with the window empty, only the gaps can refuse a group.
    a_r6_empty_window_never_blocks: assert property (
        @(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> (allow_o == gap_ok[grp_i]));

endmodule

// File: tb/act_window_gate_bench.sv
`timescale 1ns/1ps
module act_window_gate_bench;
    localparam int GW  = 3;
    localparam int SG  = 2;
    localparam int CG  = 3;
    localparam int WIN = 12;
    localparam int NA  = 4;
    localparam int HOR = (WIN > CG) ? WIN : CG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          act = 1'b0;
    logic [GW-1:0] grp = '0;
    logic          allow;

    int checks = 0;
    int errors = 0;
    int now = 0;
    bit done = 0;
    int hist_t[$];
    int hist_g[$];

    act_window_gate #(
        .GRP_W(GW), .SAME_GAP(SG), .CROSS_GAP(CG), .WINDOW(WIN), .WIN_ACTS(NA)
    ) u_act_window_gate (
        .clk(clk), .rst_n(rst_n), .act_i(act), .grp_i(grp), .allow_o(allow)
    );

    always #10 clk = ~clk;

    // Reference decision from the accepted history alone.
    task automatic model_eval(input int g, output bit ok, output string why);
        int in_win;
        bit same_bad;
        bit cross_bad;
        in_win = 0; same_bad = 0; cross_bad = 0;
        foreach (hist_t[i]) begin
            int d;
            d = now - hist_t[i];
            if (d < WIN) in_win++;
            if (hist_g[i] == g && d < SG) same_bad = 1;
            if (hist_g[i] != g && d < CG) cross_bad = 1;
        end
        ok = (in_win < NA) && !same_bad && !cross_bad;
        if (in_win >= NA)  why = "R3";
        else if (same_bad) why = "R4";
        else if (cross_bad) why = "R5";
        else               why = "R6";
    endtask

    // One cycle: drive, compare flag with model, record admission.
    task automatic step(input bit a, input int g, input string phase);
        bit    exp;
        string why;
        @(negedge clk);
        act = a;
        grp = GW'(g);
        #1;
        while (hist_t.size() > 0 && (now - hist_t[0]) >= HOR) begin
            hist_t.delete(0);
            hist_g.delete(0);
        end
        model_eval(g, exp, why);
        checks++;
        if (allow !== exp) begin
            errors++;
            $display("FAIL %s [%s] cycle %0d grp %0d: allow=%b expected=%b",
                     why, phase, now, g, allow, exp);
        end
        if (a && exp) begin
            hist_t.push_back(now);
            hist_g.push_back(g);
        end
        now++;
    endtask

    // Reset for two cycles, then check every group is open (R9).
    task automatic reset_dut();
        @(negedge clk);
        act = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        hist_t.delete();
        hist_g.delete();
        for (int g = 0; g < (1 << GW); g++) begin
            grp = GW'(g);
            #1;
            checks++;
            if (allow !== 1'b1) begin
                errors++;
                $display("FAIL R9 reset state grp %0d: allow=%b expected=1", g, allow);
            end
        end
    endtask

    initial begin : main
        reset_dut();

        // R1 R4 R5 group pair sweep: first ACT, then request every cycle.
        for (int g1 = 0; g1 < (1 << GW); g1++) begin
            for (int g2 = 0; g2 < (1 << GW); g2++) begin
                reset_dut();
                step(1, g1, "R1 pair sweep");
                for (int k = 0; k < CG + 1; k++) step(1, g2, "R1 pair sweep");
                for (int k = 0; k < HOR; k++) step(0, k % 8, "R1 idle");
            end
        end

        // R2 R8 fill window with rotating groups, fifth request on expiry edge.
        reset_dut();
        for (int k = 0; k < 3 * WIN; k++) step(1, k % 8, "R2 R8 expiry");

        // R7 refused pulses to the same group must not delay its reopening.
        reset_dut();
        step(1, 2, "R7 ignored");
        for (int k = 0; k < 6; k++) step(1, 2, "R7 ignored");
        for (int k = 0; k < 6; k++) step(1, 5, "R7 ignored");

        // R3 R4 R5 R6 random streams at three densities.
        reset_dut();
        for (int dens = 20; dens <= 90; dens += 35) begin
            for (int k = 0; k < 3000; k++)
                step(($urandom % 100) < dens, $urandom % 8, "R3 R6 random");
        end

        // R9 reset while window is full.
        for (int k = 0; k < 20; k++) step(1, k % 8, "R9 fill");
        reset_dut();
        for (int k = 0; k < 40; k++) step(1, $urandom % 8, "R9 after");

        @(negedge clk);
        act = 1'b0;
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired: cycles=200000 expected completion earlier");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule